// File: doc/BRIEF.md
# Clock Manager Control Register Interface

This block is the register front end and power sequencer for an on-chip clock generator. Fabric logic talks to it over a small asynchronous port. A 3-bit address selects one of eight byte registers. A write is committed once per assertion of the write enable. A read returns the addressed register for as long as the read enable stays high, and the read bus is released whenever the read enable is low. Both enables are brought into the system clock domain through two-flop synchronizers.

The highest register (address 7) is the control register. It holds these bits:

- an enable
- separate reset bits for the delay-locked and phase-locked loop logic
- a bit that allows running before configuration completes
- a bit that shields the block from the chip-wide reset

From these bits, the configuration-done input and the global reset input, the block produces:

- a power enable
- two loop reset outputs
- a five-state power sequence with counted wake-up, acquisition and shutdown periods

If the read and write enables are high at the same time, the write is dropped and a sticky error flag is set.

Top module: `clkmgr_ctrl`

## Requirements
- R1: After system reset, all eight registers read 0x00, `pwr_state` is 0 (off), and `pwr_en`, `rw_err` and `rd_drive` are low.
- R2: A rising edge of `wr_en` writes `wr_data` into the register at `addr` within three clock cycles. `wr_en` must be held for at least three cycles, and address and data must stay stable while it is held.
- R3: Two cycles after `rd_en` rises, `rd_drive` is high and `rd_data` shows the addressed register. If `addr` changes while `rd_en` stays high, the newly addressed register is returned.
- R4: Two cycles after `rd_en` falls, `rd_drive` is low and `rd_data` is high-impedance.
- R5: If the synchronized read and write enables are high in the same cycle, `rw_err` is set and stays set until reset, and no register is written.
- R6: Control bit 0 set, with the run condition met, moves `pwr_state` through the following codes:
  - off (0)
  - wake-up (1) for `WAKE_CYC` cycles
  - acquiring (2) for `ACQ_CYC` cycles
  - running (3)

  `pwr_en` is high in states 1 to 3.
- R7: When the run condition is lost, `pwr_en` falls on the next cycle. The state goes to shutdown (4) for `SHUT_CYC` cycles and then to off (0).
- R8: Control bit 1 drives `dll_rst` and control bit 2 drives `pll_rst`. Setting them changes no other register and does not disturb the power sequence.
- R9: The run condition is control bit 0 AND (`cfg_done` OR control bit 6). With bit 6 at 0 and `cfg_done` low, the state stays off.
- R10: Global reset (`gbl_rst_n` low) clears every register, `rw_err` and the power sequence only while control bit 7 is 0. With bit 7 at 1, global reset has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset, asynchronous |
| gbl_rst_n | input | 1 | Active-low chip-wide reset, maskable |
| cfg_done | input | 1 | Configuration complete |
| rd_en | input | 1 | Read enable, asynchronous |
| wr_en | input | 1 | Write enable, asynchronous; commits on its rising edge |
| addr | input | 3 | Register select |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, high-impedance when not reading |
| rd_drive | output | 1 | High while `rd_data` is driven |
| pwr_en | output | 1 | Power enable for the analog section |
| dll_rst | output | 1 | Delay-locked loop logic reset |
| pll_rst | output | 1 | Phase-locked loop logic reset |
| pwr_state | output | 3 | Power state: 0 off, 1 wake, 2 acquire, 3 run, 4 shutdown |
| rw_err | output | 1 | Sticky read/write overlap flag |

## Verification
A register write and a register read can reach the synchronized domain in the same clock cycle. The bench provokes this by raising both enables on one falling edge with a new value for a register that already holds known data. It then judges the outcome in three ways:
- the error flag must rise;
- a later read of that register must still return the old value;
- the flag must survive a masked global reset, and it must clear only on an unmasked one.

// File: rtl/clkmgr_pkg.sv
package clkmgr_pkg;

  typedef enum logic [2:0] {
    PS_OFF  = 3'd0,
    PS_WAKE = 3'd1,
    PS_ACQ  = 3'd2,
    PS_RUN  = 3'd3,
    PS_SHUT = 3'd4
  } pwr_state_e;

  // control register bit positions (behavioural: software writes these)
  localparam int CTL_EN     = 0;
  localparam int CTL_DLL    = 1;
  localparam int CTL_PLL    = 2;
  localparam int CTL_CFGRUN = 6;
  localparam int CTL_GMASK  = 7;

endpackage

// File: rtl/clkmgr_sync.sv
module clkmgr_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] sh;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sh[0] <= '0;
          else        sh[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sh[s] <= '0;
          else        sh[s] <= sh[s-1];
      end
    end
  endgenerate

  assign q = sh[STAGES-1];

endmodule

// File: rtl/clkmgr_regfile.sv
module clkmgr_regfile #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grst,
  input  logic              re_s,
  input  logic              we_s,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_val,
  output logic [DATA_W-1:0] ctl,
  output logic              err
);

  localparam int NREG = 1 << ADDR_W;

  logic [NREG-1:0][DATA_W-1:0] mem;
  logic we_d;
  logic commit;
  logic wr_ok;

  assign commit = we_s & ~we_d;
  assign wr_ok  = commit & ~re_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) we_d <= 1'b0;
    else        we_d <= we_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem <= '0;
    end else if (grst) begin
      mem <= '0;
    end else begin
      for (int i = 0; i < NREG; i++)
        if (wr_ok && addr == ADDR_W'(i)) mem[i] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)             err <= 1'b0;
    else if (grst)          err <= 1'b0;
    else if (re_s && we_s)  err <= 1'b1;

  assign rd_val = mem[addr];
  assign ctl    = mem[NREG-1];

  // R2
  write_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && !grst) |=> mem[$past(addr)] == $past(wdata));

  // R5
  overlap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n || grst)
    (re_s && we_s) |=> err);

  // R5
  overlap_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && re_s && !grst) |=> $stable(mem));

  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n || grst)
    err |=> err);

endmodule

// File: rtl/clkmgr_seq.sv
module clkmgr_seq
  import clkmgr_pkg::*;
#(
  parameter int WAKE_CYC = 4,
  parameter int ACQ_CYC  = 6,
  parameter int SHUT_CYC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       grst,
  input  logic       run_ok,
  output pwr_state_e state,
  output logic       pwr_en
);

  localparam int MAXC  = (WAKE_CYC > ACQ_CYC) ?
                         ((WAKE_CYC > SHUT_CYC) ? WAKE_CYC : SHUT_CYC) :
                         ((ACQ_CYC > SHUT_CYC) ? ACQ_CYC : SHUT_CYC);
  localparam int CNT_W = $clog2(MAXC + 1);

  pwr_state_e       nxt;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    nxt = state;
    unique case (state)
      PS_OFF:  if (run_ok) nxt = PS_WAKE;
      PS_WAKE: if (!run_ok) nxt = PS_SHUT;
               else if (cnt == CNT_W'(WAKE_CYC - 1)) nxt = PS_ACQ;
      PS_ACQ:  if (!run_ok) nxt = PS_SHUT;
               else if (cnt == CNT_W'(ACQ_CYC - 1)) nxt = PS_RUN;
      PS_RUN:  if (!run_ok) nxt = PS_SHUT;
      PS_SHUT: if (cnt == CNT_W'(SHUT_CYC - 1)) nxt = PS_OFF;
      default: nxt = PS_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PS_OFF;
      cnt   <= '0;
    end else if (grst) begin
      state <= PS_OFF;
      cnt   <= '0;
    end else begin
      state <= nxt;
      cnt   <= (nxt != state) ? '0 : cnt + 1'b1;
    end
  end

  assign pwr_en = (state == PS_WAKE) || (state == PS_ACQ) || (state == PS_RUN);

  // R7
  pwr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_ok |=> !pwr_en);

  // R6
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || grst)
    (state == PS_RUN && run_ok) |=> state == PS_RUN);

  // R6
  acq_entry_chk: assert property (@(posedge clk) disable iff (!rst_n || grst)
    (state == PS_WAKE && nxt == PS_ACQ) |=> state == PS_ACQ);

  // R7
  shut_exit_chk: assert property (@(posedge clk) disable iff (!rst_n || grst)
    (state == PS_SHUT) |=> (state == PS_SHUT || state == PS_OFF));

endmodule

// File: rtl/clkmgr_ctrl.sv
module clkmgr_ctrl
  import clkmgr_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 8,
  parameter int WAKE_CYC = 4,
  parameter int ACQ_CYC  = 6,
  parameter int SHUT_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gbl_rst_n,
  input  logic              cfg_done,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_drive,
  output logic              pwr_en,
  output logic              dll_rst,
  output logic              pll_rst,
  output logic [2:0]        pwr_state,
  output logic              rw_err
);

  logic [1:0]        en_s;
  logic              re_s;
  logic              we_s;
  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] ctl;
  logic              grst;
  logic              run_ok;
  pwr_state_e        st;

  clkmgr_sync #(.W(2), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({rd_en, wr_en}),
    .q     (en_s)
  );
  assign re_s = en_s[1];
  assign we_s = en_s[0];

  assign grst   = !gbl_rst_n && !ctl[CTL_GMASK];
  assign run_ok = ctl[CTL_EN] && (cfg_done || ctl[CTL_CFGRUN]);

  clkmgr_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .grst   (grst),
    .re_s   (re_s),
    .we_s   (we_s),
    .addr   (addr),
    .wdata  (wr_data),
    .rd_val (rd_val),
    .ctl    (ctl),
    .err    (rw_err)
  );

  clkmgr_seq #(.WAKE_CYC(WAKE_CYC), .ACQ_CYC(ACQ_CYC), .SHUT_CYC(SHUT_CYC)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .grst   (grst),
    .run_ok (run_ok),
    .state  (st),
    .pwr_en (pwr_en)
  );

  assign pwr_state = st;
  assign dll_rst   = ctl[CTL_DLL];
  assign pll_rst   = ctl[CTL_PLL];
  assign rd_drive  = re_s;
  assign rd_data   = re_s ? rd_val : 'z;

  // R10
  grst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grst |=> (pwr_state == 3'd0 && ctl == '0 && !rw_err));

  // R10
  gmask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gbl_rst_n && ctl[CTL_GMASK] && !we_s) |=> $stable(ctl));

endmodule

// File: tb/clkmgr_ctrl_test.sv
module clkmgr_ctrl_test;

  localparam int WAKE = 4;
  localparam int ACQ  = 6;
  localparam int SHUT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gbl_rst_n = 1'b1;
  logic cfg_done = 1'b0;
  logic rd_en = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic rd_drive, pwr_en, dll_rst, pll_rst, rw_err;
  logic [2:0] pwr_state;

  always #2.5 clk = ~clk;

  clkmgr_ctrl #(.WAKE_CYC(WAKE), .ACQ_CYC(ACQ), .SHUT_CYC(SHUT)) uut (
    .clk(clk), .rst_n(rst_n), .gbl_rst_n(gbl_rst_n), .cfg_done(cfg_done),
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .rd_drive(rd_drive), .pwr_en(pwr_en),
    .dll_rst(dll_rst), .pll_rst(pll_rst), .pwr_state(pwr_state), .rw_err(rw_err)
  );

  int vectors = 0;
  int fails = 0;
  int exp_st[$];
  int exp_rd[$];
  string tag_rd[$];
  logic pending = 1'b0;
  int prev_st = 0;
  int dwell = 0;
  int e_st;
  int e_rd;
  string e_tag;

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected state transitions and read data
  always begin
    @(negedge clk);
    #1;
    if (rst_n) begin
      if (int'(pwr_state) != prev_st) begin
        e_st = (exp_st.size() > 0) ? exp_st.pop_front() : -1;
        chk("R6 state order", int'(pwr_state), e_st);
        if (prev_st == 1) chk("R6 wake dwell", dwell, WAKE);
        if (prev_st == 2) chk("R6 acquire dwell", dwell, ACQ);
        if (prev_st == 4) chk("R7 shutdown dwell", dwell, SHUT);
        if (pwr_state == 3'd1) chk("R6 pwr_en on wake", int'(pwr_en), 1);
        if (pwr_state == 3'd4) chk("R7 pwr_en off in shutdown", int'(pwr_en), 0);
        prev_st = int'(pwr_state);
        dwell = 1;
      end else begin
        dwell++;
      end
      if (pending && rd_drive) begin
        e_rd  = exp_rd.pop_front();
        e_tag = tag_rd.pop_front();
        chk(e_tag, int'(rd_data), e_rd);
        pending = 1'b0;
      end
    end
  end

  task automatic wr(input int a, input int d);
    addr = 3'(a);
    wr_data = 8'(d);
    wr_en = 1'b1;
    repeat (4) @(negedge clk);
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    addr = 3'(a);
    rd_en = 1'b1;
    exp_rd.push_back(exp);
    tag_rd.push_back(tag);
    pending = 1'b1;
    wait (pending == 1'b0);
    @(negedge clk);
  endtask

  task automatic rd_end();
    rd_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R4 bus released", int'(rd_drive), 0);
  endtask

  task automatic grst_pulse();
    gbl_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    gbl_rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 state off", int'(pwr_state), 0);
    chk("R1 pwr_en low", int'(pwr_en), 0);
    chk("R1 err low", int'(rw_err), 0);
    chk("R1 rd_drive low", int'(rd_drive), 0);
    rd(3, 8'h00, "R1 reg3 cleared");
    rd(7, 8'h00, "R1 ctrl cleared");
    rd_end();

    // R2 writes, R3 reads with address change under RE
    wr(2, 8'hA5);
    wr(5, 8'h3C);
    rd(2, 8'hA5, "R2 reg2 write");
    rd(5, 8'h3C, "R3 address change reg5");
    rd(2, 8'hA5, "R3 address change reg2");
    rd_end();

    // R9 gated by cfg_done with bit6 clear
    wr(7, 8'h01);
    repeat (20) @(negedge clk);
    chk("R9 held off before cfg_done", int'(pwr_state), 0);
    chk("R9 pwr_en low before cfg_done", int'(pwr_en), 0);

    // R6 power-up sequence
    exp_st.push_back(1); exp_st.push_back(2); exp_st.push_back(3);
    cfg_done = 1'b1;
    repeat (20) @(negedge clk);
    chk("R6 reaches run", int'(pwr_state), 3);
    chk("R6 pwr_en in run", int'(pwr_en), 1);

    // R8 loop resets keep registers and sequence
    wr(7, 8'h07);
    chk("R8 dll_rst", int'(dll_rst), 1);
    chk("R8 pll_rst", int'(pll_rst), 1);
    chk("R8 still running", int'(pwr_state), 3);
    rd(2, 8'hA5, "R8 reg2 kept");
    rd(5, 8'h3C, "R8 reg5 kept");
    rd_end();
    wr(7, 8'h03);
    chk("R8 dll_rst alone", int'(dll_rst), 1);
    chk("R8 pll_rst cleared", int'(pll_rst), 0);
    wr(7, 8'h01);
    chk("R8 dll_rst cleared", int'(dll_rst), 0);

    // R5 overlap of read and write
    addr = 3'd2;
    wr_data = 8'hFF;
    rd_en = 1'b1;
    wr_en = 1'b1;
    repeat (5) @(negedge clk);
    rd_en = 1'b0;
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 err set", int'(rw_err), 1);
    rd(2, 8'hA5, "R5 write dropped");
    rd_end();
    repeat (4) @(negedge clk);
    chk("R5 err sticky", int'(rw_err), 1);

    // R10 masked global reset
    wr(7, 8'h81);
    grst_pulse();
    chk("R10 masked keeps run", int'(pwr_state), 3);
    chk("R10 masked keeps err", int'(rw_err), 1);
    rd(2, 8'hA5, "R10 masked keeps reg2");
    rd(7, 8'h81, "R10 masked keeps ctrl");
    rd_end();

    // R7 shutdown
    exp_st.push_back(4); exp_st.push_back(0);
    wr(7, 8'h00);
    repeat (10) @(negedge clk);
    chk("R7 back to off", int'(pwr_state), 0);
    chk("R7 pwr_en low", int'(pwr_en), 0);

    // R9 run during configuration with bit6
    cfg_done = 1'b0;
    exp_st.push_back(1); exp_st.push_back(2); exp_st.push_back(3);
    wr(7, 8'h41);
    repeat (20) @(negedge clk);
    chk("R9 runs with bit6", int'(pwr_state), 3);

    // R10 unmasked global reset clears everything
    exp_st.push_back(0);
    grst_pulse();
    chk("R10 state off", int'(pwr_state), 0);
    chk("R10 err cleared", int'(rw_err), 0);
    chk("R10 pwr_en low", int'(pwr_en), 0);
    rd(2, 8'h00, "R10 reg2 cleared");
    rd(7, 8'h00, "R10 ctrl cleared");
    rd_end();

    repeat (5) @(negedge clk);
    chk("R6 expected transitions consumed", exp_st.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule